// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

This block raises a periodic interrupt from a slow timebase. The slow clock is modelled as a single-cycle enable, `tick_i`, that pulses at 32768 Hz in the system clock domain. Software first writes a reload value while the timer is stopped. The timer then counts down once per tick. When it expires, it sets a raw periodic status bit and reloads itself. For an interrupt rate of f, software writes a reload value of 32768 / f.

The timer shares a word-addressed register window with the neighbouring clock logic. That is why the interrupt bit sits at bit 1 of the mask, raw, masked and clear registers, and why the timer registers start at byte offset 0x20. The reload register is locked while the timer runs. An optional self-start control bit starts the timer as soon as a reload value is written.

Word map (`addr_i` is the byte offset divided by 4):

| Word | Byte | Register |
|---|---|---|
| 4 | 0x10 | mask |
| 5 | 0x14 | raw |
| 6 | 0x18 | masked |
| 7 | 0x1c | clear |
| 8 | 0x20 | current value |
| 9 | 0x24 | reload |
| 10 | 0x28 | control (bit 1 run, bit 0 self-start) |

Top module: `tick_timer`

## Requirements
- R1: After reset, the value, reload, control, mask and raw registers all read 0 and `irq_o` is 0.
- R2: While control bit 1 (run) is 0, a write to word 9 stores the reload value, and reading word 9 returns it.
- R3: While run is 1, writes to word 9 are ignored, and word 9 keeps returning the old reload value.
- R4: When run goes from 0 to 1, the counter at word 8 is loaded with the reload value.
- R5: While running, each cycle with `tick_i` high decrements the counter, and cycles without a tick leave it unchanged. A tick that finds the counter at 1 sets raw bit 1 (word 5) and reloads the counter, so the expiry period equals the reload value in ticks.
- R6: A reload value of 0 behaves as 1: the counter loads 1 and the timer expires on every tick.
- R7: Clearing run freezes the counter, and later ticks do not change word 8.
- R8: With control bit 0 (self-start) set and run clear, a write to word 9 sets run and loads the counter with the written value.
- R9: Writing 1 to bit 1 of word 7 clears raw bit 1, and writing 0 there has no effect. If an expiry happens in the same cycle as a clear, the bit stays set.
- R10: Bit 1 of word 4 is the interrupt mask. Word 6 bit 1 equals raw AND mask, and `irq_o` follows that masked bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 32768 Hz timebase enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Masked periodic interrupt |

## Verification
A table of reload values is applied in turn: 0, 1, 2, 3, 5 and 7. For each one the bench counts the ticks to the first expiry and reads the value reloaded afterwards. This separates the zero-as-one clamp, the single-tick case and a genuine off-by-one in the reload point. Directed sequences then cover the following:
- Writes to the reload register while running, which the lock must reject.
- Stopping between ticks, where the counter must freeze.
- Starting through the self-start bit instead of the run bit.
- Clear writes of 0 and 1, and mask values of 0 and 1, which tell the raw status apart from the masked status.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    W_MASK   = 4'd4,
    W_RAW    = 4'd5,
    W_MASKED = 4'd6,
    W_CLEAR  = 4'd7,
    W_VALUE  = 4'd8,
    W_RELOAD = 4'd9,
    W_CTRL   = 4'd10
  } word_e;

  localparam int CTRL_SELF_BIT = 0;
  localparam int CTRL_RUN_BIT  = 1;
  localparam int IRQ_BIT       = 1;
endpackage

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q <= CNT_W'(1));
  assign expire_o = run_i & tick_i & ~load_i & at_end;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (expire_o)     cnt_q <= reload_i;
    else if (run_i && tick_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  // R5 decrement by one per tick above the end point
  a_r5_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !load_i && !at_end |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R7 stopped counter holds
  a_r7_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !load_i |=> $stable(cnt_q));
  // R4 start loads requested value
  a_r4_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/tick_irq_status.sv
module tick_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic raw_o,
  output logic mask_o
);
  logic raw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (set_i)      raw_q <= 1'b1;   // set wins over clear
      else if (clr_i) raw_q <= 1'b0;
      if (mask_we_i)  mask_q <= mask_d_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;

  // R5 expiry latches raw status
  a_r5_raw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> raw_q);
  // R9 clear without set drops status
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !raw_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] reload_q, cnt, load_raw, load_val;
  logic             run_q, run_d, self_q, self_d;
  logic             wr_ctrl, wr_reload, wr_clear, wr_mask, load, expire;
  logic             raw, mask;

  assign wr_ctrl   = wr_en_i && (addr_i == W_CTRL);
  assign wr_reload = wr_en_i && (addr_i == W_RELOAD) && !run_q;  // locked while running
  assign wr_clear  = wr_en_i && (addr_i == W_CLEAR) && wdata_i[IRQ_BIT];
  assign wr_mask   = wr_en_i && (addr_i == W_MASK);

  always_comb begin
    run_d  = run_q;
    self_d = self_q;
    if (wr_ctrl) begin
      run_d  = wdata_i[CTRL_RUN_BIT];
      self_d = wdata_i[CTRL_SELF_BIT];
    end else if (wr_reload && self_q) begin
      run_d = 1'b1;
    end
  end

  assign load     = run_d & ~run_q;
  assign load_raw = wr_reload ? wdata_i[CNT_W-1:0] : reload_q;
  assign load_val = (load_raw == '0) ? CNT_W'(1) : load_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      run_q    <= 1'b0;
      self_q   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
      run_q  <= run_d;
      self_q <= self_d;
    end
  end

  tick_downcounter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .reload_i   ((reload_q == '0) ? CNT_W'(1) : reload_q),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  tick_irq_status i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (expire),
    .clr_i     (wr_clear),
    .mask_we_i (wr_mask),
    .mask_d_i  (wdata_i[IRQ_BIT]),
    .raw_o     (raw),
    .mask_o    (mask)
  );

  assign irq_o = raw & mask;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      W_MASK:   rdata_o[IRQ_BIT] = mask;
      W_RAW:    rdata_o[IRQ_BIT] = raw;
      W_MASKED: rdata_o[IRQ_BIT] = raw & mask;
      W_VALUE:  rdata_o = DATA_W'(cnt);
      W_RELOAD: rdata_o = DATA_W'(reload_q);
      W_CTRL: begin
        rdata_o[CTRL_RUN_BIT]  = run_q;
        rdata_o[CTRL_SELF_BIT] = self_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  // R3 reload register locked while running
  a_r3_reload_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == W_RELOAD && run_q |=> $stable(reload_q));
  // R6 running counter never sits at zero
  a_r6_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt != '0);
  // R8 self-start reload write starts the timer
  a_r8_self_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == W_RELOAD && !run_q && self_q |=> run_q);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {reload written, expected period in ticks}
  localparam int unsigned VEC [6][2] = '{'{0,1}, '{1,1}, '{2,2}, '{3,3}, '{5,5}, '{7,7}};

  always #4 clk = ~clk;

  tick_timer i_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int period;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd8, v);  chk("R1 value", v, 0);
    rd(4'd9, v);  chk("R1 reload", v, 0);
    rd(4'd10, v); chk("R1 ctrl", v, 0);
    rd(4'd4, v);  chk("R1 mask", v, 0);
    rd(4'd5, v);  chk("R1 raw", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R5 R6 table of reload values and periods
    for (int i = 0; i < 6; i++) begin
      wr(4'd10, 0);
      wr(4'd7, 2);
      wr(4'd9, VEC[i][0]);
      rd(4'd9, v); chk("R2 reload readback", v, VEC[i][0]);
      wr(4'd10, 2);
      rd(4'd8, v); chk("R4 start value", v, VEC[i][1]);
      period = 0;
      for (int n = 1; n <= 40; n++) begin
        pulse_tick();
        rd(4'd5, v);
        if (v[1]) begin period = n; break; end
      end
      chk("R5 R6 period", period, VEC[i][1]);
      rd(4'd8, v); chk("R5 value after expiry", v, VEC[i][1]);
    end

    // R5 decrement and no move without tick
    wr(4'd10, 0);
    wr(4'd9, 5);
    wr(4'd10, 2);
    repeat (3) @(negedge clk);
    rd(4'd8, v); chk("R5 no tick hold", v, 5);
    pulse_tick();
    rd(4'd8, v); chk("R5 decrement", v, 4);

    // R3 reload lock while running
    wr(4'd9, 9);
    rd(4'd9, v); chk("R3 lock", v, 5);

    // R7 freeze
    pulse_tick();
    wr(4'd10, 0);
    repeat (3) pulse_tick();
    rd(4'd8, v); chk("R7 freeze", v, 3);

    // R8 self-start
    wr(4'd10, 1);
    rd(4'd10, v); chk("R8 ctrl self only", v, 1);
    wr(4'd9, 4);
    rd(4'd10, v); chk("R8 run set", v, 3);
    rd(4'd8, v);  chk("R8 start value", v, 4);

    // R9 clear behaviour
    wr(4'd10, 0);
    wr(4'd9, 1);
    wr(4'd10, 2);
    pulse_tick();
    wr(4'd10, 0);
    rd(4'd5, v); chk("R9 raw set", v, 2);
    wr(4'd7, 0);
    rd(4'd5, v); chk("R9 clear zero no effect", v, 2);

    // R10 mask
    wr(4'd4, 0);
    rd(4'd6, v); chk("R10 masked off", v, 0);
    chk("R10 irq off", {31'b0, irq}, 0);
    wr(4'd4, 2);
    rd(4'd6, v); chk("R10 masked on", v, 2);
    chk("R10 irq on", {31'b0, irq}, 1);

    // R9 clear one
    wr(4'd7, 2);
    rd(4'd5, v); chk("R9 clear", v, 0);
    chk("R10 irq after clear", {31'b0, irq}, 0);

    // R9 set wins over simultaneous clear
    wr(4'd10, 2);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 4'd7; wdata = 2;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(4'd5, v); chk("R9 set wins", v, 2);

    done = 1'b1;
    finish_run();
  end
endmodule